// File: doc/BRIEF.md
# Posted-Write Data Parity Error Handler

This block guards the data phases of posted writes that cross a two-port bridge, in both directions. On each side it captures the address/data word and the active-low byte enables of every data phase it accepts as a target. It then takes the parity bit that follows one clock later and checks even parity. A failed check drives that side's active-low parity-error strobe, provided the side's response enable is on. The failure also sets a sticky "error detected" flag for that side. The transaction is never stopped: the write completes, and a per-phase "bad" flag goes out alongside the posted data so that the posted-write storage outside the block can carry it.

On the far bus, a parity generator builds the parity bit for each outgoing data phase. It inverts that bit for a phase whose carried flag is set, so the far target sees the same corruption. While the bridge drives a downstream write on the secondary bus as initiator, the block also watches the error strobe driven by the secondary target. It records such a report in a separate sticky flag, but only when the secondary response enable is on. All enables arrive as plain inputs. Each sticky flag clears through its own write-one-to-clear pulse.

Top module: `pw_parity_guard`

## Requirements
- R1: While reset is held and in the first cycle after it is released, both error strobes are released (output enable 0, strobe value 1). All sticky flags, both flag outputs and both generated parity bits read 0.
- R2: A data phase accepted at clock edge k on a side has its parity bit sampled at edge k+1. From edge k+1 to edge k+2 that side's flag-valid output is 1. Its flag-bad output is 1 exactly when the XOR of all data bits, all byte-enable bits and the parity bit is 1 (even parity fails). The primary side feeds the downstream flag and the secondary side feeds the upstream flag.
- R3: When the check of R2 fails and the side's response enable is 1 at edge k+2, the side's strobe is driven low with output enable 1 from edge k+2 to edge k+3. The primary side uses the primary enable and the secondary side uses the secondary enable.
- R4: When the side's response enable is 0, a failed check never drives the strobe: the output enable stays 0.
- R5: After each low cycle the strobe is driven high with output enable 1 for one cycle, then released. Failures on consecutive data phases give consecutive low cycles, followed by a single high cycle.
- R6: The side's "error detected" flag becomes 1 at edge k+2 after a failed check, whatever its response enable. It then stays 1 until cleared.
- R7: A clear pulse sampled at an edge zeroes a sticky flag. If a set and a clear reach the same edge, the flag stays 1.
- R8: For an outgoing data phase presented at edge j, the side's generated parity bit, valid from edge j+1, is the XOR of the outgoing data and byte enables, inverted when the phase's bad flag is 1. It holds its value when no phase is presented.
- R9: The secondary "target reported error" flag is set at an edge where the initiator-active input is 1, the target strobe input is 0 and the secondary response enable is 1. It is not set when any of these three conditions does not hold.
- R10: The target-reported flag clears on its own clear pulse, independently of the other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pri_dphase | input | 1 | Primary-side data phase accepted this cycle (downstream write) |
| pri_ad | input | DW | Primary data word |
| pri_cbe_n | input | DW/8 | Primary byte enables, active low |
| pri_par | input | 1 | Primary parity bit, one cycle after its data phase |
| sec_dphase | input | 1 | Secondary-side data phase accepted this cycle (upstream write) |
| sec_ad | input | DW | Secondary data word |
| sec_cbe_n | input | DW/8 | Secondary byte enables, active low |
| sec_par | input | 1 | Secondary parity bit, one cycle after its data phase |
| pri_resp_en | input | 1 | Primary parity response enable |
| sec_resp_en | input | 1 | Secondary parity response enable |
| pri_perr_n | output | 1 | Primary error strobe value, active low |
| pri_perr_oe | output | 1 | Primary error strobe output enable |
| sec_perr_n | output | 1 | Secondary error strobe value, active low |
| sec_perr_oe | output | 1 | Secondary error strobe output enable |
| ds_flag_vld | output | 1 | Downstream phase check result valid |
| ds_flag_bad | output | 1 | Downstream phase carried bad parity |
| us_flag_vld | output | 1 | Upstream phase check result valid |
| us_flag_bad | output | 1 | Upstream phase carried bad parity |
| sec_tx_dphase | input | 1 | Outgoing data phase on secondary bus |
| sec_tx_ad | input | DW | Outgoing secondary data word |
| sec_tx_cbe_n | input | DW/8 | Outgoing secondary byte enables |
| sec_tx_bad | input | 1 | Carried bad flag for this outgoing phase |
| sec_tx_par | output | 1 | Generated secondary parity bit |
| pri_tx_dphase | input | 1 | Outgoing data phase on primary bus |
| pri_tx_ad | input | DW | Outgoing primary data word |
| pri_tx_cbe_n | input | DW/8 | Outgoing primary byte enables |
| pri_tx_bad | input | 1 | Carried bad flag for this outgoing phase |
| pri_tx_par | output | 1 | Generated primary parity bit |
| sec_mst_wr_act | input | 1 | Bridge is initiator of a write data phase on the secondary bus |
| sec_tgt_perr_n | input | 1 | Error strobe from the secondary target, active low |
| pri_err_det | output | 1 | Sticky primary error detected |
| sec_err_det | output | 1 | Sticky secondary error detected |
| sec_tgt_err_det | output | 1 | Sticky secondary target-reported error |
| pri_err_det_clr | input | 1 | Clear pulse for pri_err_det |
| sec_err_det_clr | input | 1 | Clear pulse for sec_err_det |
| sec_tgt_err_det_clr | input | 1 | Clear pulse for sec_tgt_err_det |

## Verification
The bench sweeps both sides, both enable values, good and bad parity, and a set of data words. For each case it samples the strobe and its output enable at the three cycles after the check. A strobe one cycle early or late, or gated by the wrong side's enable, shows up there. So does a strobe that skips the high cycle before release. A pair of consecutive bad phases catches a driver that releases between errors or sends a high cycle in the middle. The clear-versus-set collision catches a flag that gives priority to the clear. Gating the detected flag with the enable shows up in the enable-off cases. The target-report cases check that a report arriving while the enable is off, or while the bridge is not initiator, leaves the flag at 0.

// File: rtl/pwpg_pkg.sv
package pwpg_pkg;
  localparam int NSIDE = 2;
  localparam int PRI   = 0;
  localparam int SEC   = 1;

  typedef enum logic [1:0] {
    PD_IDLE    = 2'd0,
    PD_ASSERT  = 2'd1,
    PD_RECOVER = 2'd2
  } perr_st_e;
endpackage

// File: rtl/pwpg_rx_check.sv
module pwpg_rx_check #(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dphase,
  input  logic [DW-1:0] ad,
  input  logic [BW-1:0] cbe_n,
  input  logic          par,
  output logic          flag_vld,
  output logic          flag_bad
);
  logic          ph_q, ph_d;
  logic [DW-1:0] ad_q;
  logic [BW-1:0] cbe_q;
  logic          vld_q, vld_d;
  logic          bad_q, bad_d;
  logic          cap_en;

  // capture enable for the data word, parity arrives one clock later
  always_comb begin
    cap_en = dphase;
    ph_d   = dphase;
    vld_d  = ph_q;
    bad_d  = ph_q & (^{ad_q, cbe_q, par});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      vld_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      vld_q <= vld_d;
      bad_q <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q  <= '0;
      cbe_q <= '0;
    end else if (cap_en) begin
      ad_q  <= ad;
      cbe_q <= cbe_n;
    end
  end

  assign flag_vld = vld_q;
  assign flag_bad = bad_q;
endmodule

// File: rtl/pwpg_perr_drv.sv
module pwpg_perr_drv
  import pwpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic err,
  input  logic resp_en,
  output logic perr_n,
  output logic perr_oe
);
  perr_st_e st_q, st_d;

  always_comb begin
    if (err && resp_en) begin
      st_d = PD_ASSERT;
    end else if (st_q == PD_ASSERT) begin
      st_d = PD_RECOVER;
    end else begin
      st_d = PD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PD_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign perr_n  = (st_q != PD_ASSERT);
  assign perr_oe = (st_q != PD_IDLE);
endmodule

// File: rtl/pwpg_sticky.sv
module pwpg_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else begin
      q_r <= q_d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/pwpg_par_gen.sv
module pwpg_par_gen #(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dphase,
  input  logic [DW-1:0] ad,
  input  logic [BW-1:0] cbe_n,
  input  logic          bad,
  output logic          par
);
  logic par_q, par_d;

  always_comb begin
    par_d = (^{ad, cbe_n}) ^ bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
    end else if (dphase) begin
      par_q <= par_d;
    end
  end

  assign par = par_q;
endmodule

// File: rtl/pw_parity_guard.sv
module pw_parity_guard
  import pwpg_pkg::*;
#(
  parameter  int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pri_dphase,
  input  logic [DW-1:0] pri_ad,
  input  logic [BW-1:0] pri_cbe_n,
  input  logic          pri_par,
  input  logic          sec_dphase,
  input  logic [DW-1:0] sec_ad,
  input  logic [BW-1:0] sec_cbe_n,
  input  logic          sec_par,
  input  logic          pri_resp_en,
  input  logic          sec_resp_en,
  output logic          pri_perr_n,
  output logic          pri_perr_oe,
  output logic          sec_perr_n,
  output logic          sec_perr_oe,
  output logic          ds_flag_vld,
  output logic          ds_flag_bad,
  output logic          us_flag_vld,
  output logic          us_flag_bad,
  input  logic          sec_tx_dphase,
  input  logic [DW-1:0] sec_tx_ad,
  input  logic [BW-1:0] sec_tx_cbe_n,
  input  logic          sec_tx_bad,
  output logic          sec_tx_par,
  input  logic          pri_tx_dphase,
  input  logic [DW-1:0] pri_tx_ad,
  input  logic [BW-1:0] pri_tx_cbe_n,
  input  logic          pri_tx_bad,
  output logic          pri_tx_par,
  input  logic          sec_mst_wr_act,
  input  logic          sec_tgt_perr_n,
  output logic          pri_err_det,
  output logic          sec_err_det,
  output logic          sec_tgt_err_det,
  input  logic          pri_err_det_clr,
  input  logic          sec_err_det_clr,
  input  logic          sec_tgt_err_det_clr
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NSIDE-1:0] rx_dph, rx_par, rx_en, f_vld, f_bad;
  logic [NSIDE-1:0] p_n, p_oe, det, det_clr;
  logic [NSIDE-1:0] tx_dph, tx_bad, tx_par;
  logic [DW-1:0]    rx_ad  [NSIDE];
  logic [BW-1:0]    rx_cbe [NSIDE];
  logic [DW-1:0]    tx_ad  [NSIDE];
  logic [BW-1:0]    tx_cbe [NSIDE];

  assign rx_dph       = {sec_dphase, pri_dphase};
  assign rx_par       = {sec_par, pri_par};
  assign rx_en        = {sec_resp_en, pri_resp_en};
  assign det_clr      = {sec_err_det_clr, pri_err_det_clr};
  assign tx_dph       = {sec_tx_dphase, pri_tx_dphase};
  assign tx_bad       = {sec_tx_bad, pri_tx_bad};
  assign rx_ad[PRI]   = pri_ad;
  assign rx_ad[SEC]   = sec_ad;
  assign rx_cbe[PRI]  = pri_cbe_n;
  assign rx_cbe[SEC]  = sec_cbe_n;
  assign tx_ad[PRI]   = pri_tx_ad;
  assign tx_ad[SEC]   = sec_tx_ad;
  assign tx_cbe[PRI]  = pri_tx_cbe_n;
  assign tx_cbe[SEC]  = sec_tx_cbe_n;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    pwpg_rx_check #(.DW(DW), .BW(BW)) u_rx (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .dphase   (rx_dph[s]),
      .ad       (rx_ad[s]),
      .cbe_n    (rx_cbe[s]),
      .par      (rx_par[s]),
      .flag_vld (f_vld[s]),
      .flag_bad (f_bad[s])
    );

    pwpg_perr_drv u_drv (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .err     (f_bad[s]),
      .resp_en (rx_en[s]),
      .perr_n  (p_n[s]),
      .perr_oe (p_oe[s])
    );

    pwpg_sticky u_det (
      .clk   (clk),
      .rst_n (rst_core_n),
      .set   (f_bad[s]),
      .clr   (det_clr[s]),
      .q     (det[s])
    );

    pwpg_par_gen #(.DW(DW), .BW(BW)) u_gen (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .dphase (tx_dph[s]),
      .ad     (tx_ad[s]),
      .cbe_n  (tx_cbe[s]),
      .bad    (tx_bad[s]),
      .par    (tx_par[s])
    );
  end

  logic tgt_set;
  assign tgt_set = sec_mst_wr_act & ~sec_tgt_perr_n & sec_resp_en;

  pwpg_sticky u_tgt_det (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set   (tgt_set),
    .clr   (sec_tgt_err_det_clr),
    .q     (sec_tgt_err_det)
  );

  assign pri_perr_n  = p_n[PRI];
  assign pri_perr_oe = p_oe[PRI];
  assign sec_perr_n  = p_n[SEC];
  assign sec_perr_oe = p_oe[SEC];
  assign ds_flag_vld = f_vld[PRI];
  assign ds_flag_bad = f_bad[PRI];
  assign us_flag_vld = f_vld[SEC];
  assign us_flag_bad = f_bad[SEC];
  assign pri_err_det = det[PRI];
  assign sec_err_det = det[SEC];
  assign pri_tx_par  = tx_par[PRI];
  assign sec_tx_par  = tx_par[SEC];
endmodule

// File: rtl/pwpg_checker.sv
module pwpg_checker #(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pri_dphase,
  input logic [DW-1:0] pri_ad,
  input logic [BW-1:0] pri_cbe_n,
  input logic          pri_par,
  input logic          sec_dphase,
  input logic [DW-1:0] sec_ad,
  input logic [BW-1:0] sec_cbe_n,
  input logic          sec_par,
  input logic          pri_resp_en,
  input logic          sec_resp_en,
  input logic          pri_perr_n,
  input logic          pri_perr_oe,
  input logic          sec_perr_n,
  input logic          sec_perr_oe,
  input logic          ds_flag_vld,
  input logic          ds_flag_bad,
  input logic          sec_tx_dphase,
  input logic [DW-1:0] sec_tx_ad,
  input logic [BW-1:0] sec_tx_cbe_n,
  input logic          sec_tx_bad,
  input logic          sec_tx_par,
  input logic          sec_mst_wr_act,
  input logic          sec_tgt_perr_n,
  input logic          pri_err_det,
  input logic          pri_err_det_clr,
  input logic          sec_tgt_err_det
);
  a_r2_flag_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pri_dphase, 2) |-> ds_flag_vld);

  a_r2_bad_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ds_flag_bad |-> ds_flag_vld);

  a_r3_pri_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pri_dphase, 3) && (^{$past(pri_ad, 3), $past(pri_cbe_n, 3), $past(pri_par, 2)})
      && $past(pri_resp_en)) |-> (!pri_perr_n && pri_perr_oe));

  a_r3_sec_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sec_dphase, 3) && (^{$past(sec_ad, 3), $past(sec_cbe_n, 3), $past(sec_par, 2)})
      && $past(sec_resp_en)) |-> (!sec_perr_n && sec_perr_oe));

  a_r4_pri_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pri_resp_en) |-> !(pri_perr_oe && !pri_perr_n));

  a_r5_pri_high_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_perr_oe) |-> $past(pri_perr_n));

  a_r5_sec_high_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_perr_oe) |-> $past(sec_perr_n));

  a_r6_pri_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pri_err_det) && !$past(pri_err_det_clr)) |-> pri_err_det);

  a_r8_sec_tx_par: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_tx_dphase) |->
      (sec_tx_par == ((^{$past(sec_tx_ad), $past(sec_tx_cbe_n)}) ^ $past(sec_tx_bad))));

  a_r9_tgt_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_tgt_err_det) |->
      ($past(sec_resp_en) && $past(sec_mst_wr_act) && !$past(sec_tgt_perr_n)));
endmodule

bind pw_parity_guard pwpg_checker #(.DW(DW), .BW(BW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .pri_dphase      (pri_dphase),
  .pri_ad          (pri_ad),
  .pri_cbe_n       (pri_cbe_n),
  .pri_par         (pri_par),
  .sec_dphase      (sec_dphase),
  .sec_ad          (sec_ad),
  .sec_cbe_n       (sec_cbe_n),
  .sec_par         (sec_par),
  .pri_resp_en     (pri_resp_en),
  .sec_resp_en     (sec_resp_en),
  .pri_perr_n      (pri_perr_n),
  .pri_perr_oe     (pri_perr_oe),
  .sec_perr_n      (sec_perr_n),
  .sec_perr_oe     (sec_perr_oe),
  .ds_flag_vld     (ds_flag_vld),
  .ds_flag_bad     (ds_flag_bad),
  .sec_tx_dphase   (sec_tx_dphase),
  .sec_tx_ad       (sec_tx_ad),
  .sec_tx_cbe_n    (sec_tx_cbe_n),
  .sec_tx_bad      (sec_tx_bad),
  .sec_tx_par      (sec_tx_par),
  .sec_mst_wr_act  (sec_mst_wr_act),
  .sec_tgt_perr_n  (sec_tgt_perr_n),
  .pri_err_det     (pri_err_det),
  .pri_err_det_clr (pri_err_det_clr),
  .sec_tgt_err_det (sec_tgt_err_det)
);

// File: tb/pw_parity_guard_tb.sv
module pw_parity_guard_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int BW    = DW / 8;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_P / 2) clk = ~clk;

  logic [1:0]    b_dph, b_par, b_en, b_clr, b_txd, b_txb;
  logic [DW-1:0] b_ad [2];
  logic [BW-1:0] b_cbe [2];
  logic [DW-1:0] b_txad [2];
  logic [BW-1:0] b_txcbe [2];
  logic          b_mst, b_tperr_n, b_tclr;

  logic pri_perr_n, pri_perr_oe, sec_perr_n, sec_perr_oe;
  logic ds_flag_vld, ds_flag_bad, us_flag_vld, us_flag_bad;
  logic sec_tx_par, pri_tx_par, pri_err_det, sec_err_det, sec_tgt_err_det;

  pw_parity_guard #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pri_dphase(b_dph[0]), .pri_ad(b_ad[0]), .pri_cbe_n(b_cbe[0]), .pri_par(b_par[0]),
    .sec_dphase(b_dph[1]), .sec_ad(b_ad[1]), .sec_cbe_n(b_cbe[1]), .sec_par(b_par[1]),
    .pri_resp_en(b_en[0]), .sec_resp_en(b_en[1]),
    .pri_perr_n(pri_perr_n), .pri_perr_oe(pri_perr_oe),
    .sec_perr_n(sec_perr_n), .sec_perr_oe(sec_perr_oe),
    .ds_flag_vld(ds_flag_vld), .ds_flag_bad(ds_flag_bad),
    .us_flag_vld(us_flag_vld), .us_flag_bad(us_flag_bad),
    .sec_tx_dphase(b_txd[1]), .sec_tx_ad(b_txad[1]), .sec_tx_cbe_n(b_txcbe[1]),
    .sec_tx_bad(b_txb[1]), .sec_tx_par(sec_tx_par),
    .pri_tx_dphase(b_txd[0]), .pri_tx_ad(b_txad[0]), .pri_tx_cbe_n(b_txcbe[0]),
    .pri_tx_bad(b_txb[0]), .pri_tx_par(pri_tx_par),
    .sec_mst_wr_act(b_mst), .sec_tgt_perr_n(b_tperr_n),
    .pri_err_det(pri_err_det), .sec_err_det(sec_err_det), .sec_tgt_err_det(sec_tgt_err_det),
    .pri_err_det_clr(b_clr[0]), .sec_err_det_clr(b_clr[1]), .sec_tgt_err_det_clr(b_tclr)
  );

  logic [1:0] o_pn, o_oe, o_fv, o_fb, o_det, o_txp;
  assign o_pn  = {sec_perr_n, pri_perr_n};
  assign o_oe  = {sec_perr_oe, pri_perr_oe};
  assign o_fv  = {us_flag_vld, ds_flag_vld};
  assign o_fb  = {us_flag_bad, ds_flag_bad};
  assign o_det = {sec_err_det, pri_err_det};
  assign o_txp = {sec_tx_par, pri_tx_par};

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one data phase on side s; expected values from the requirement timing
  task automatic phase(input int s, input logic [31:0] ad, input logic [3:0] cbe,
                       input bit bad, input bit en);
    bit hit;
    hit = bad & en;
    b_en[s] = en;
    b_dph[s] = 1'b1; b_ad[s] = ad; b_cbe[s] = cbe;
    tick();                                        // edge k
    b_dph[s] = 1'b0; b_par[s] = (^{ad, cbe}) ^ bad;
    tick();                                        // edge k+1
    b_par[s] = 1'b0;
    check("R2 flag valid", 32'(o_fv[s]), 32'd1);
    check("R2 flag bad", 32'(o_fb[s]), 32'(bad));
    tick();                                        // edge k+2
    check("R3/R4 strobe value", 32'(o_pn[s]), 32'(!hit));
    check("R3/R4 strobe enable", 32'(o_oe[s]), 32'(hit));
    check("R6 detected set", 32'(o_det[s]), 32'(bad));
    tick();                                        // edge k+3
    check("R5 high cycle value", 32'(o_pn[s]), 32'd1);
    check("R5 high cycle enable", 32'(o_oe[s]), 32'(hit));
    tick();                                        // edge k+4
    check("R5 released", 32'(o_oe[s]), 32'd0);
    check("R6 detected holds", 32'(o_det[s]), 32'(bad));
    b_clr[s] = 1'b1;
    tick();
    b_clr[s] = 1'b0;
    check("R7 cleared", 32'(o_det[s]), 32'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    b_dph = '0; b_par = '0; b_en = '0; b_clr = '0; b_txd = '0; b_txb = '0;
    b_mst = 1'b0; b_tperr_n = 1'b1; b_tclr = 1'b0;
    for (int s = 0; s < 2; s++) begin
      b_ad[s] = '0; b_cbe[s] = '0; b_txad[s] = '0; b_txcbe[s] = '0;
    end
    repeat (3) tick();
    for (int s = 0; s < 2; s++) begin
      check("R1 reset strobe enable", 32'(o_oe[s]), 32'd0);
      check("R1 reset strobe value", 32'(o_pn[s]), 32'd1);
      check("R1 reset detected", 32'(o_det[s]), 32'd0);
      check("R1 reset flag", 32'(o_fv[s]), 32'd0);
      check("R1 reset tx parity", 32'(o_txp[s]), 32'd0);
    end
    check("R1 reset target flag", 32'(sec_tgt_err_det), 32'd0);
    rst_n = 1'b1;
    repeat (4) tick();

    // sweep: side x enable x parity x data patterns
    for (int s = 0; s < 2; s++)
      for (int en = 0; en < 2; en++)
        for (int bad = 0; bad < 2; bad++)
          for (int i = 0; i < 6; i++)
            phase(s, 32'(i) * 32'h9E37_79B9 ^ 32'(s << 7), 4'(i * 5 + bad), bit'(bad), bit'(en));

    // R5: consecutive bad phases on primary
    b_en = 2'b11;
    b_dph[0] = 1'b1; b_ad[0] = 32'h1234_5678; b_cbe[0] = 4'h3;
    tick();
    b_ad[0] = 32'hCAFE_0001; b_cbe[0] = 4'hE;
    b_par[0] = ~(^{32'h1234_5678, 4'h3});
    tick();
    b_dph[0] = 1'b0; b_par[0] = ~(^{32'hCAFE_0001, 4'hE});
    tick();
    b_par[0] = 1'b0;
    check("R5 back-to-back first low", 32'({o_oe[0], o_pn[0]}), 32'b10);
    tick();
    check("R5 back-to-back second low", 32'({o_oe[0], o_pn[0]}), 32'b10);
    tick();
    check("R5 back-to-back high", 32'({o_oe[0], o_pn[0]}), 32'b11);
    tick();
    check("R5 back-to-back release", 32'(o_oe[0]), 32'd0);
    b_clr[0] = 1'b1; tick(); b_clr[0] = 1'b0;

    // R7: clear and set meet at the same edge
    b_dph[1] = 1'b1; b_ad[1] = 32'h0F0F_0F0F; b_cbe[1] = 4'h1;
    tick();
    b_dph[1] = 1'b0; b_par[1] = 1'b0;              // true parity is 1, so this is bad
    tick();
    b_clr[1] = 1'b1;
    tick();
    b_clr[1] = 1'b0;
    check("R7 set wins over clear", 32'(o_det[1]), 32'd1);
    b_clr[1] = 1'b1; tick(); b_clr[1] = 1'b0;
    check("R7 later clear", 32'(o_det[1]), 32'd0);
    repeat (3) tick();

    // R8: parity generation sweep with carried bad flag
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++) begin
        logic [31:0] a;
        logic [3:0]  c;
        bit          bd;
        a = 32'(i) * 32'h0101_0103 + 32'(s);
        c = 4'(i);
        bd = bit'(i[0] ^ i[2]);
        b_txd[s] = 1'b1; b_txad[s] = a; b_txcbe[s] = c; b_txb[s] = bd;
        tick();
        b_txd[s] = 1'b0; b_txad[s] = ~a; b_txb[s] = ~bd;
        check("R8 generated parity", 32'(o_txp[s]), 32'((^{a, c}) ^ bd));
        tick();
        check("R8 parity held", 32'(o_txp[s]), 32'((^{a, c}) ^ bd));
      end

    // R9 / R10: target-reported errors
    for (int en = 0; en < 2; en++)
      for (int act = 0; act < 2; act++) begin
        b_en[1] = bit'(en); b_mst = bit'(act); b_tperr_n = 1'b0;
        tick();
        b_mst = 1'b0; b_tperr_n = 1'b1;
        check("R9 target report", 32'(sec_tgt_err_det), 32'(en & act));
        check("R10 other flags untouched", 32'(o_det), 32'd0);
        b_tclr = 1'b1; tick(); b_tclr = 1'b0;
        check("R10 target flag cleared", 32'(sec_tgt_err_det), 32'd0);
      end
    b_en[1] = 1'b1; b_mst = 1'b1; b_tperr_n = 1'b1;
    tick();
    b_mst = 1'b0;
    check("R9 no report without strobe", 32'(sec_tgt_err_det), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule